// File: doc/BRIEF.md
# External Reset Pin Manager

This block lives in the reset controller of a chip and runs on the slow always-on clock. It owns one bidirectional active-low reset pin. Two flip-flops synchronise the pin. A low level seen on the synchronised copy is a user event. Configuration decides what such an event does. It can request a user reset from the reset sequencer, it can raise an interrupt, or it can do both.

The reset sequencer can also ask the block to pull the pin low, which resets external devices. The pull-down lasts 2^(N+1) slow-clock cycles, where N is a 4-bit length setting. While the block drives the pin, it reads back its own low level, so the event logic is masked. The mask stays on for two more cycles after release, which gives the line time to rise before it is checked again.

Status shows the current synchronised pin level and a sticky event flag. A one-cycle read strobe clears the flag. The configuration bits come from a register held in the always-on domain, so they are inputs to this block and survive the other resets.

Top module: `extrst_pin_mgr`

## Requirements
- R1: `sts_level` equals the value `pin_in` had two rising clock edges earlier (two-flop synchroniser), and resets to 1.
- R2: When `sts_level` is 0, the mask is inactive and `cfg_rst_en` is 1, `user_rst` is 1 in that same cycle.
- R3: While `cfg_rst_en` is 0, `user_rst` stays 0 whatever the pin does.
- R4: `irq` is 1 exactly when `sts_event` is 1 and `cfg_irq_en` is 1.
- R5: A `seq_req` of 1 sampled at a clock edge makes `pin_drive_low` 1 from that edge for exactly 2^(`cfg_len`+1) cycles, where `cfg_len` is an unsigned 4-bit value.
- R6: A new `seq_req` while the pin is already being driven restarts the full length from the new request.
- R7: The mask is active while `pin_drive_low` is 1 and for the two cycles after it falls. While it is active, `user_rst` stays 0 and `sts_event` is not set.
- R8: `sts_event` is set at the edge following a cycle with an unmasked low `sts_level`. A 1 on `sts_rd` clears it at the next edge. When a new event and a read fall in the same cycle, the event wins and the flag stays 1.
- R9: After a synchronous reset, `pin_drive_low`, `user_rst`, `sts_event` and `irq` are 0 and `sts_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Raw level read from the external reset pin (asynchronous) |
| pin_drive_low | output | 1 | Open-drain enable: 1 pulls the pin low |
| seq_req | input | 1 | Reset sequencer asks for a pin pulse |
| user_rst | output | 1 | User reset request to the reset sequencer |
| cfg_rst_en | input | 1 | 1 lets a low pin request a user reset |
| cfg_irq_en | input | 1 | 1 lets the sticky event raise `irq` |
| cfg_len | input | 4 | Pulse length exponent N, pulse = 2^(N+1) cycles |
| sts_level | output | 1 | Synchronised pin level |
| sts_event | output | 1 | Sticky flag: an unmasked low level was seen |
| sts_rd | input | 1 | One-cycle strobe: status was read, clear the flag |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume three things about the inputs. `sts_rd` is a single-cycle strobe. `cfg_len` is not changed in the middle of a pulse. The pin reads back low whenever the block drives it, which holds because the bench models the pin as a wired-AND of the external pull-down and `pin_drive_low`. The random stimulus holds external lows and gaps for several cycles at a time. It changes `cfg_len` only while no pulse is running, and keeps lengths short so that many pulses fit in a run. Directed cases then cover restart, read-versus-event collisions, and a disabled user reset.

// File: rtl/extrst_pkg.sv
package extrst_pkg;

    localparam int LEN_W      = 4;
    localparam int CNT_W      = (1 << LEN_W) + 1;
    localparam int SYNC_DEPTH = 2;
    localparam int BLANK_CYC  = 2;
    localparam int BLANK_W    = $clog2(BLANK_CYC + 1);

    typedef struct packed {
        logic             rst_en;
        logic             irq_en;
        logic [LEN_W-1:0] len;
    } pin_cfg_t;

    typedef struct packed {
        logic drive;
        logic guard;
    } drv_state_t;

    function automatic logic [CNT_W-1:0] pulse_cycles(input logic [LEN_W-1:0] len);
        logic [CNT_W-1:0] one;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        return one << (int'(len) + 1);
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int   DEPTH   = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [DEPTH-1:0] stage;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= RST_VAL;
                    else     stage[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= RST_VAL;
                    else     stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage[DEPTH-1];
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
    import extrst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output drv_state_t       st
);
    logic [CNT_W-1:0]   cnt;
    logic [BLANK_W-1:0] blank;

    localparam logic [CNT_W-1:0]   CNT_ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [BLANK_W-1:0] BLANK_ONE = {{(BLANK_W-1){1'b0}}, 1'b1};
    localparam logic [BLANK_W-1:0] BLANK_LD  = BLANK_W'(BLANK_CYC);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            blank <= '0;
        end else if (start) begin
            cnt   <= pulse_cycles(len);
            blank <= '0;
        end else begin
            if (cnt != '0)
                cnt <= cnt - CNT_ONE;
            if (cnt == CNT_ONE)
                blank <= BLANK_LD;
            else if (blank != '0)
                blank <= blank - BLANK_ONE;
        end
    end

    always_comb begin
        st.drive = (cnt != '0);
        st.guard = (blank != '0);
    end

    // R5: a request always has the pin driven at the next cycle
    assert_req_drives_R5: assert property (@(posedge clk) disable iff (rst)
        start |=> st.drive);

    // R7: release of the pin is always followed by the guard window
    assert_guard_after_release_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(st.drive) |-> st.guard);

    // R7: guard is never on while driving
    assert_guard_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(st.drive && st.guard));
endmodule

// File: rtl/event_tracker.sv
module event_tracker (
    input  logic clk,
    input  logic rst,
    input  logic pin_lvl,
    input  logic mask,
    input  logic rst_en,
    input  logic irq_en,
    input  logic rd,
    output logic user_rst,
    output logic sticky,
    output logic irq
);
    logic seen_low;

    always_comb begin
        seen_low = !pin_lvl && !mask;
        user_rst = seen_low && rst_en;
        irq      = sticky && irq_en;
    end

    always_ff @(posedge clk) begin
        if (rst)           sticky <= 1'b0;
        else if (seen_low) sticky <= 1'b1;
        else if (rd)       sticky <= 1'b0;
    end

    // R4: an interrupt never appears without the sticky flag
    assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> sticky);

    // R8: without a read the flag holds
    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (sticky && !rd) |=> sticky);

    // R8: an event overrides a simultaneous read
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (!pin_lvl && !mask && rd) |=> sticky);
endmodule

// File: rtl/extrst_pin_mgr.sv
module extrst_pin_mgr
    import extrst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_in,
    output logic             pin_drive_low,
    input  logic             seq_req,
    output logic             user_rst,
    input  logic             cfg_rst_en,
    input  logic             cfg_irq_en,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             sts_level,
    output logic             sts_event,
    input  logic             sts_rd,
    output logic             irq
);
    pin_cfg_t   cfg;
    drv_state_t drv;
    logic       pin_lvl;
    logic       mask;

    always_comb begin
        cfg.rst_en = cfg_rst_en;
        cfg.irq_en = cfg_irq_en;
        cfg.len    = cfg_len;
    end

    pin_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .q_sync  (pin_lvl)
    );

    pulse_timer u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (seq_req),
        .len   (cfg.len),
        .st    (drv)
    );

    assign mask = drv.drive || drv.guard;

    event_tracker u_evt (
        .clk      (clk),
        .rst      (rst),
        .pin_lvl  (pin_lvl),
        .mask     (mask),
        .rst_en   (cfg.rst_en),
        .irq_en   (cfg.irq_en),
        .rd       (sts_rd),
        .user_rst (user_rst),
        .sticky   (sts_event),
        .irq      (irq)
    );

    assign pin_drive_low = drv.drive;
    assign sts_level     = pin_lvl;

    // R7: the block's own pulse never turns into a user reset
    assert_no_self_reset_R7: assert property (@(posedge clk) disable iff (rst)
        pin_drive_low |-> !user_rst);

    // R3: disabled user reset stays silent
    assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (rst)
        !cfg_rst_en |-> !user_rst);

    // R2: a user reset only follows a low synchronised level
    assert_reset_needs_low_R2: assert property (@(posedge clk) disable iff (rst)
        user_rst |-> !sts_level);
endmodule

// File: tb/extrst_pin_mgr_tb.sv
module extrst_pin_mgr_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_low = 1'b0;
    logic       pin_in;
    logic       pin_drive_low;
    logic       seq_req = 1'b0;
    logic       user_rst;
    logic       cfg_rst_en = 1'b1;
    logic       cfg_irq_en = 1'b0;
    logic [3:0] cfg_len = 4'd0;
    logic       sts_level;
    logic       sts_event;
    logic       sts_rd = 1'b0;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference state, built from the requirements
    logic        m_s1, m_s2, m_sticky;
    int unsigned m_cnt, m_blank;

    always #2 clk = ~clk;

    assign pin_in = !(ext_low || pin_drive_low);

    extrst_pin_mgr u_dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_drive_low(pin_drive_low),
        .seq_req(seq_req), .user_rst(user_rst), .cfg_rst_en(cfg_rst_en),
        .cfg_irq_en(cfg_irq_en), .cfg_len(cfg_len), .sts_level(sts_level),
        .sts_event(sts_event), .sts_rd(sts_rd), .irq(irq)
    );

    function automatic int unsigned exp_len(input logic [3:0] n);
        return 32'd1 << (int'(n) + 1);
    endfunction

    function automatic bit m_mask();
        return (m_cnt != 0) || (m_blank != 0);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic pin_now, low_seen;
        int unsigned c, b;
        if (rst) begin
            m_s1 = 1'b1; m_s2 = 1'b1; m_sticky = 1'b0; m_cnt = 0; m_blank = 0;
            return;
        end
        pin_now  = !(ext_low || (m_cnt != 0));
        low_seen = !m_s2 && !m_mask();
        c = m_cnt; b = m_blank;
        if (low_seen)    m_sticky = 1'b1;
        else if (sts_rd) m_sticky = 1'b0;
        m_s2 = m_s1; m_s1 = pin_now;
        if (seq_req) begin
            m_cnt = exp_len(cfg_len); m_blank = 0;
        end else begin
            if (c != 0) m_cnt = c - 1;
            if (c == 1) m_blank = 2;
            else if (b != 0) m_blank = b - 1;
        end
    endtask

    task automatic compare();
        bit e_ur;
        e_ur = !m_s2 && !m_mask() && cfg_rst_en;
        chk(sts_level == m_s2, "R1 sts_level", int'(sts_level), int'(m_s2));
        chk(pin_drive_low == (m_cnt != 0), "R5/R6 pin_drive_low", int'(pin_drive_low), int'(m_cnt != 0));
        chk(user_rst == e_ur, "R2/R3/R7 user_rst", int'(user_rst), int'(e_ur));
        chk(sts_event == m_sticky, "R8 sts_event", int'(sts_event), int'(m_sticky));
        chk(irq == (m_sticky && cfg_irq_en), "R4 irq", int'(irq), int'(m_sticky && cfg_irq_en));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic pulse_req();
        seq_req = 1'b1; step(); seq_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 70000 && m_mask(); i++) step();
        step(); step();
    endtask

    task automatic measure(input logic [3:0] n, input string tag);
        int cnt;
        cfg_len = n;
        pulse_req();
        cnt = 0;
        while (pin_drive_low && cnt < 70000) begin cnt++; step(); end
        chk(cnt == int'(exp_len(n)), tag, cnt, int'(exp_len(n)));
        wait_idle();
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        int pulse_r6;
        seed = $urandom(32'd4242);
        @(negedge clk);
        step(); step(); step();
        // R9: reset state
        chk(pin_drive_low == 1'b0 && user_rst == 1'b0 && sts_event == 1'b0 && irq == 1'b0
            && sts_level == 1'b1, "R9 reset state", int'({pin_drive_low, user_rst, sts_event, irq, sts_level}), 1);
        rst = 1'b0;
        step(); step();

        // R1/R2: external low propagates in two edges and requests reset
        ext_low = 1'b1;
        step();
        chk(sts_level == 1'b1, "R1 one edge not yet", int'(sts_level), 1);
        step();
        chk(sts_level == 1'b0 && user_rst == 1'b1, "R2 low seen", int'({sts_level, user_rst}), 1);
        ext_low = 1'b0;
        step(); step();
        // R8 read clears the flag
        chk(sts_event == 1'b1, "R8 flag set", int'(sts_event), 1);
        sts_rd = 1'b1; step(); sts_rd = 1'b0;
        chk(sts_event == 1'b0, "R8 read clears", int'(sts_event), 0);

        // R8: event and read in the same cycle, event wins
        ext_low = 1'b1; step(); step();
        sts_rd = 1'b1; step(); sts_rd = 1'b0;
        chk(sts_event == 1'b1, "R8 event beats read", int'(sts_event), 1);
        ext_low = 1'b0; step(); step();
        sts_rd = 1'b1; step(); sts_rd = 1'b0;

        // R3: user reset disabled, irq path instead (R4)
        cfg_rst_en = 1'b0; cfg_irq_en = 1'b1;
        ext_low = 1'b1; step(); step();
        chk(user_rst == 1'b0, "R3 disabled no reset", int'(user_rst), 0);
        step();
        chk(irq == 1'b1, "R4 irq raised", int'(irq), 1);
        ext_low = 1'b0; step(); step();
        sts_rd = 1'b1; step(); sts_rd = 1'b0;
        chk(irq == 1'b0, "R4 irq cleared by read", int'(irq), 0);
        cfg_rst_en = 1'b1; cfg_irq_en = 1'b0;

        // R5: pulse lengths
        measure(4'd0, "R5 length N=0");
        measure(4'd2, "R5 length N=2");
        measure(4'd5, "R5 length N=5");
        // R7: own pulse left no event behind
        chk(sts_event == 1'b0, "R7 no self event", int'(sts_event), 0);

        // R6: restart while driving
        cfg_len = 4'd2;
        pulse_req();
        step(); step(); step();
        pulse_req();
        pulse_r6 = 1;
        while (pin_drive_low && pulse_r6 < 1000) begin pulse_r6++; step(); end
        chk(pulse_r6 == 9, "R6 restart full length", pulse_r6, 9);
        wait_idle();

        // random phase
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 4) ext_low = !ext_low;
            seq_req = (r >= 96);
            sts_rd  = (r >= 40 && r < 46);
            if (r == 50) cfg_rst_en = !cfg_rst_en;
            if (r == 51) cfg_irq_en = !cfg_irq_en;
            if (!m_mask() && r == 52) cfg_len = 4'($urandom % 4);
            step();
        end
        seq_req = 1'b0; sts_rd = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule